// File: doc/BRIEF.md
# Carry-with-memory-bit sequencer

This block executes the single-bit boolean instructions of a small processor core. Each one combines the carry flag with one bit of a byte in memory, or inverts that bit in place. After a start pulse the unit fetches a two-byte operand from a pointer given by the core. The top bits of that operand select the bit inside the byte. The remaining bits form the absolute byte address. The unit then reads the byte and either updates carry or writes the modified byte back.

The core drives an opcode, the operand pointer and its present carry, then waits for `done`. The memory port has registered address and strobes. Read data is taken in the same cycle that the read strobe is held. An opcode outside the supported set is refused at once with a one-cycle `err` pulse.

Top module: `mbit_carry_unit`

## Requirements
- R1: After reset, `carry_out`, `done`, `err`, `busy`, `mem_rd` and `mem_wr` are all 0.
- R2: A start with a supported opcode is counted as cycle 1 on the next clock. Cycle 1 reads `op_ptr` (low operand byte) and cycle 2 reads `op_ptr+1` (high operand byte).
- R3: Cycle 3 reads the target byte. Its address is operand bits [12:0] zero-extended to 16 bits (the three top address bits are 0). The bit index is operand bits [15:13], i.e. high byte bits [7:5].
- R4: Opcode 0x4A: new carry = carry_in AND bit. `done` is high in cycle 3.
- R5: Opcode 0x6A: new carry = carry_in AND NOT bit. `done` is high in cycle 3.
- R6: Opcode 0x8A: new carry = carry_in XOR bit. Cycle 4 is idle (no read, no write) and `done` is high in cycle 4.
- R7: Opcode 0x0A: new carry = carry_in OR bit. Opcode 0x2A: new carry = carry_in OR NOT bit. Both have an idle cycle 4 with `done` high in it.
- R8: Opcode 0xEA writes the target byte with the selected bit inverted back to the same address in cycle 4, with `done` high. `carry_out` becomes carry_in.
- R9: Any other opcode gives `err` high for one cycle on the next clock. There is no memory access, no `done`, and `carry_out` is left unchanged.
- R10: `start` is ignored while `busy` is high; no second operation is started.
- R11: `carry_out` changes only at the clock edge that ends a cycle in which `done` is high. `done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken when not busy) |
| opcode | input | 8 | Instruction code |
| op_ptr | input | 16 | Address of the low operand byte |
| carry_in | input | 1 | Carry value at start |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid while mem_rd is high |
| carry_out | output | 1 | Resulting carry |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Final cycle of an operation |
| err | output | 1 | Unsupported opcode pulse |

## Verification
The bench builds the unit with its defaults: an 8-bit data width and a 16-bit address. That gives a 3-bit bit index and a 13-bit byte field. It therefore reaches bit index 7, a target address with bit 12 set, and nonzero bits above bit 12 in the high operand byte that must not leak into the address. With these widths every opcode can be run against both values of the selected bit and of the incoming carry. A toggle followed by a bit test on the same byte shows the write-back at the ports.

// File: rtl/mbit_pkg.sv
package mbit_pkg;

  localparam logic [7:0] OPC_AND  = 8'h4A;
  localparam logic [7:0] OPC_ANDN = 8'h6A;
  localparam logic [7:0] OPC_XOR  = 8'h8A;
  localparam logic [7:0] OPC_OR   = 8'h0A;
  localparam logic [7:0] OPC_ORN  = 8'h2A;
  localparam logic [7:0] OPC_FLIP = 8'hEA;

  typedef enum logic [2:0] {
    K_AND, K_ANDN, K_XOR, K_OR, K_ORN, K_FLIP, K_BAD
  } bit_kind_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LO, ST_HI, ST_TGT, ST_TAIL
  } seq_state_t;

endpackage

// File: rtl/mbit_decode.sv
module mbit_decode
  import mbit_pkg::*;
(
  input  logic [7:0] opcode,
  output bit_kind_t  kind,
  output logic       valid,
  output logic       long_op
);
  always_comb begin
    valid   = 1'b1;
    long_op = 1'b1;
    kind    = K_BAD;
    case (opcode)
      OPC_AND:  begin kind = K_AND;  long_op = 1'b0; end
      OPC_ANDN: begin kind = K_ANDN; long_op = 1'b0; end
      OPC_XOR:  kind = K_XOR;
      OPC_OR:   kind = K_OR;
      OPC_ORN:  kind = K_ORN;
      OPC_FLIP: kind = K_FLIP;
      default:  begin valid = 1'b0; long_op = 1'b0; end
    endcase
  end
endmodule

// File: rtl/mbit_addr.sv
module mbit_addr #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic [DATA_W-1:0]         lo,
  input  logic [DATA_W-1:0]         hi,
  output logic [ADDR_W-1:0]         tgt,
  output logic [$clog2(DATA_W)-1:0] idx
);
  localparam int IDX_W   = $clog2(DATA_W);
  localparam int OPND_W  = 2 * DATA_W;
  localparam int BYTE_AW = OPND_W - IDX_W;

  logic [OPND_W-1:0] opnd;

  always_comb begin
    opnd = {hi, lo};
    idx  = opnd[OPND_W-1 -: IDX_W];
    tgt  = '0;
    tgt[BYTE_AW-1:0] = opnd[BYTE_AW-1:0];
  end
endmodule

// File: rtl/mbit_bitop.sv
module mbit_bitop
  import mbit_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  bit_kind_t                 kind,
  input  logic                      cin,
  input  logic [DATA_W-1:0]         byte_in,
  input  logic [$clog2(DATA_W)-1:0] idx,
  output logic                      cout,
  output logic [DATA_W-1:0]         byte_out
);
  logic [DATA_W-1:0] mask;
  logic              sel;

  for (genvar g = 0; g < DATA_W; g++) begin : g_mask
    assign mask[g] = (idx == g);
  end

  always_comb begin
    sel      = |(byte_in & mask);
    byte_out = byte_in ^ mask;
    case (kind)
      K_AND:   cout = cin & sel;
      K_ANDN:  cout = cin & ~sel;
      K_XOR:   cout = cin ^ sel;
      K_OR:    cout = cin | sel;
      K_ORN:   cout = cin | ~sel;
      default: cout = cin;
    endcase
  end
endmodule

// File: rtl/mbit_carry_unit.sv
module mbit_carry_unit
  import mbit_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [7:0]        opcode,
  input  logic [ADDR_W-1:0] op_ptr,
  input  logic              carry_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              carry_out,
  output logic              busy,
  output logic              done,
  output logic              err
);
  localparam int IDX_W   = $clog2(DATA_W);
  localparam int BYTE_AW = 2 * DATA_W - IDX_W;

  seq_state_t        state;
  bit_kind_t         dec_kind, kind_q;
  logic              dec_valid, dec_long, long_q;
  logic              cin_q, pend_q;
  logic [DATA_W-1:0] lo_q;
  logic [IDX_W-1:0]  idx_q, calc_idx;
  logic [ADDR_W-1:0] calc_tgt;
  logic              op_cout;
  logic [DATA_W-1:0] op_byte;
  logic              accept;

  mbit_decode u_dec (
    .opcode (opcode),
    .kind   (dec_kind),
    .valid  (dec_valid),
    .long_op(dec_long)
  );

  mbit_addr #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_addr (
    .lo (lo_q),
    .hi (mem_rdata),
    .tgt(calc_tgt),
    .idx(calc_idx)
  );

  mbit_bitop #(.DATA_W(DATA_W)) u_op (
    .kind    (kind_q),
    .cin     (cin_q),
    .byte_in (mem_rdata),
    .idx     (idx_q),
    .cout    (op_cout),
    .byte_out(op_byte)
  );

  assign accept = start && (state == ST_IDLE);
  assign busy   = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      kind_q    <= K_BAD;
      long_q    <= 1'b0;
      cin_q     <= 1'b0;
      pend_q    <= 1'b0;
      lo_q      <= '0;
      idx_q     <= '0;
      mem_addr  <= '0;
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      mem_wdata <= '0;
      carry_out <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      err <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            if (dec_valid) begin
              kind_q   <= dec_kind;
              long_q   <= dec_long;
              cin_q    <= carry_in;
              mem_addr <= op_ptr;
              mem_rd   <= 1'b1;
              state    <= ST_LO;
            end else begin
              err <= 1'b1;
            end
          end
        end
        ST_LO: begin
          lo_q     <= mem_rdata;
          mem_addr <= mem_addr + 1'b1;
          state    <= ST_HI;
        end
        ST_HI: begin
          mem_addr <= calc_tgt;
          idx_q    <= calc_idx;
          done     <= !long_q;
          state    <= ST_TGT;
        end
        ST_TGT: begin
          mem_rd <= 1'b0;
          if (!long_q) begin
            carry_out <= op_cout;
            done      <= 1'b0;
            state     <= ST_IDLE;
          end else begin
            pend_q    <= op_cout;
            mem_wr    <= (kind_q == K_FLIP);
            mem_wdata <= op_byte;
            done      <= 1'b1;
            state     <= ST_TAIL;
          end
        end
        ST_TAIL: begin
          carry_out <= pend_q;
          mem_wr    <= 1'b0;
          done      <= 1'b0;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R11
  carry_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |=> $stable(carry_out));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  wb_same_addr_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> ($past(mem_rd) && mem_addr == $past(mem_addr)));

  // R3
  tgt_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TGT) |-> ((mem_addr >> BYTE_AW) == '0));

  // R9
  err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> (!mem_rd && !mem_wr && !done && !busy));

  // R6
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

endmodule

// File: tb/mbit_carry_unit_tb.sv
module mbit_carry_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic        is_err;
    int          cycles;
    logic [15:0] ptr;
    logic [15:0] tgt;
    logic        carry;
    logic        wr;
    logic [7:0]  wdata;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [15:0] op_ptr = 16'h0;
  logic        carry_in = 1'b0;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        carry_out, busy, done, err;

  logic [7:0] mem [0:4095];
  exp_t       sbq[$];
  int         n_chk = 0;
  int         n_fail = 0;
  logic       model_carry = 1'b0;
  bit         finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign mem_rdata = mem[mem_addr[11:0]];
  always @(posedge clk) if (mem_wr) mem[mem_addr[11:0]] <= mem_wdata;

  mbit_carry_unit dut_i (
    .clk(clk), .rst(rst), .start(start), .opcode(opcode), .op_ptr(op_ptr),
    .carry_in(carry_in), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .carry_out(carry_out),
    .busy(busy), .done(done), .err(err)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic model_op(input logic [7:0] op, input logic c, input logic b);
    case (op)
      8'h4A: return c & b;
      8'h6A: return c & ~b;
      8'h8A: return c ^ b;
      8'h0A: return c | b;
      8'h2A: return c | ~b;
      default: return c;
    endcase
  endfunction

  task automatic place(input logic [15:0] ptr, input logic [12:0] tgt, input logic [2:0] idx, input logic [7:0] hi_extra);
    mem[ptr[11:0]]      = tgt[7:0];
    mem[ptr[11:0] + 1]  = {idx, tgt[12:8]} | hi_extra;
  endtask

  // Driver: computes the expected item, pushes it, then pulses start.
  task automatic issue(input logic [7:0] op, input logic [15:0] ptr, input logic cin);
    exp_t e;
    logic [7:0] lo, hi, bt;
    logic [2:0] ix;
    bit known;
    known = (op == 8'h4A || op == 8'h6A || op == 8'h8A || op == 8'h0A || op == 8'h2A || op == 8'hEA);
    lo = mem[ptr[11:0]];
    hi = mem[ptr[11:0] + 1];
    ix = hi[7:5];
    e.ptr    = ptr;
    e.tgt    = {3'b000, hi[4:0], lo};
    bt       = mem[e.tgt[11:0]];
    e.is_err = !known;
    e.cycles = (op == 8'h4A || op == 8'h6A) ? 3 : 4;
    e.wr     = (op == 8'hEA);
    e.wdata  = bt ^ (8'h01 << ix);
    e.carry  = known ? model_op(op, cin, bt[ix]) : model_carry;
    sbq.push_back(e);
    @(posedge clk); #1;
    start = 1'b1; opcode = op; op_ptr = ptr; carry_in = cin;
    @(posedge clk); #1;
    start = 1'b0; carry_in = ~cin;
    repeat (6) @(posedge clk);
    #1;
  endtask

  // Monitor: pops the scoreboard and compares cycle by cycle.
  initial begin
    exp_t cur;
    int   cyc = 0;
    bit   active = 0;
    bit   chk_c = 0;
    forever begin
      @(negedge clk);
      if (rst) continue;
      if (chk_c) begin
        check(carry_out == cur.carry, "R4-R8 carry result", carry_out, cur.carry);
        model_carry = cur.carry;
        chk_c = 0;
      end
      if (!active && start && !busy) begin
        active = 1; cyc = 0;
        if (sbq.size() == 0) begin
          check(0, "R10 start with empty scoreboard", 1, 0);
          active = 0;
        end else cur = sbq.pop_front();
      end else if (active) begin
        cyc++;
        if (cur.is_err) begin
          check(err == 1'b1, "R9 err pulse", err, 1);
          check(!mem_rd && !mem_wr && !done, "R9 no access", {mem_rd, mem_wr, done}, 0);
          check(carry_out == model_carry, "R9 carry kept", carry_out, model_carry);
          active = 0;
        end else begin
          if (cyc == 1) check(mem_rd && mem_addr == cur.ptr, "R2 low fetch", mem_addr, cur.ptr);
          if (cyc == 2) check(mem_rd && mem_addr == cur.ptr + 16'd1, "R2 high fetch", mem_addr, cur.ptr + 16'd1);
          if (cyc == 3) check(mem_rd && mem_addr == cur.tgt, "R3 target address", mem_addr, cur.tgt);
          if (cyc == 4) begin
            check(!mem_rd && mem_wr == cur.wr, "R6 R7 R8 cycle4 bus", {mem_rd, mem_wr}, {1'b0, cur.wr});
            if (cur.wr) begin
              check(mem_addr == cur.tgt, "R8 write address", mem_addr, cur.tgt);
              check(mem_wdata == cur.wdata, "R8 write data", mem_wdata, cur.wdata);
            end
          end
          if (done) begin
            check(cyc == cur.cycles, "R4 R5 R6 R7 cycle count", cyc, cur.cycles);
            active = 0; chk_c = 1;
          end else if (cyc > 5) begin
            check(0, "R11 done missing", cyc, cur.cycles);
            active = 0;
          end
        end
      end else if (done || err) begin
        check(0, "R10 unexpected completion", {done, err}, 0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 37 + 11);
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check(carry_out == 0 && done == 0 && err == 0 && busy == 0 && mem_rd == 0 && mem_wr == 0,
          "R1 reset outputs", {carry_out, done, err, busy, mem_rd, mem_wr}, 0);
    rst = 1'b0;
    @(posedge clk); #1;

    mem[12'h345] = 8'h5A;
    place(16'h0010, 13'h0345, 3'd1, 8'h00);
    issue(8'h4A, 16'h0010, 1'b1);            // R4 bit=1 -> 1
    place(16'h0010, 13'h0345, 3'd0, 8'h00);
    issue(8'h4A, 16'h0010, 1'b1);            // R4 bit=0 -> 0
    issue(8'h6A, 16'h0010, 1'b1);            // R5 bit=0 -> 1
    place(16'h0020, 13'h0345, 3'd1, 8'h00);
    issue(8'h6A, 16'h0020, 1'b1);            // R5 bit=1 -> 0
    issue(8'h8A, 16'h0020, 1'b1);            // R6 1^1 -> 0
    issue(8'h8A, 16'h0010, 1'b1);            // R6 1^0 -> 1
    issue(8'h0A, 16'h0010, 1'b0);            // R7 0|0 -> 0
    place(16'h0030, 13'h0345, 3'd3, 8'h00);
    issue(8'h0A, 16'h0030, 1'b0);            // R7 0|1 -> 1
    issue(8'h2A, 16'h0010, 1'b0);            // R7 0|~0 -> 1
    issue(8'h2A, 16'h0030, 1'b0);            // R7 0|~1 -> 0

    // R8 toggle bit 7 then bit 0, then read back through R4
    mem[12'hABC] = 8'h5A;
    place(16'h0040, 13'h0ABC, 3'd7, 8'h00);
    issue(8'hEA, 16'h0040, 1'b1);
    check(mem[12'hABC] == 8'hDA, "R8 memory after toggle", mem[12'hABC], 8'hDA);
    place(16'h0050, 13'h0ABC, 3'd0, 8'h00);
    issue(8'hEA, 16'h0050, 1'b0);
    check(mem[12'hABC] == 8'hDB, "R8 memory after second toggle", mem[12'hABC], 8'hDB);
    issue(8'h4A, 16'h0040, 1'b1);            // R8 read-back bit7 = 1

    // R3 address bit 12 set, index 5
    mem[12'hF00] = 8'h20;
    place(16'h0060, 13'h1F00, 3'd5, 8'h00);
    issue(8'h0A, 16'h0060, 1'b0);

    // R9 unsupported opcodes leave carry alone
    issue(8'h4B, 16'h0010, 1'b0);
    issue(8'hFF, 16'h0010, ~model_carry);

    // R10 start held during a running operation
    issue(8'h8A, 16'h0010, 1'b0);
    begin
      exp_t e;
      e.is_err = 0; e.cycles = 3; e.ptr = 16'h0010; e.tgt = 16'h0345;
      e.carry = 1'b0; e.wr = 0; e.wdata = 8'h00;
      sbq.push_back(e);                      // R10: 0x4A, bit0=0, cin=1 -> 0
      @(posedge clk); #1;
      start = 1'b1; opcode = 8'h4A; op_ptr = 16'h0010; carry_in = 1'b1;
      @(posedge clk); #1;
      opcode = 8'hEA; op_ptr = 16'h0040;
      @(posedge clk); #1;
      @(posedge clk); #1;
      start = 1'b0;
      repeat (6) @(posedge clk);
      #1;
      check(sbq.size() == 0, "R10 scoreboard drained", sbq.size(), 0);
      check(mem[12'hABC] == 8'hDB, "R10 no hidden toggle", mem[12'hABC], 8'hDB);
      check(carry_out == 1'b0, "R10 carry from first op", carry_out, 0);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule